// File: doc/BRIEF.md
# SPI Register Interface with Indirect Memory Access

This block is the serial front end of a timekeeping core. It acts as an SPI slave that opens a 7-bit register space to a host: time, alarm, control and status registers live in the core and are reached through a synchronous read/write port, while a 256-byte scratch memory is held inside the block and reached through an address register and a data register. Each transfer starts with a command byte whose top bit selects write or read and whose low seven bits give the starting register. Every further byte in the same chip-select window is a data byte, and the register pointer advances after each one.

The serial pins are oversampled in the system clock domain. The idle level of the serial clock when chip select falls selects between the two shift-on-leading-edge modes, so the host may idle the clock either high or low. Read data for the next byte is fetched while the current byte is still shifting, so a burst runs without gaps. A one-cycle snapshot strobe tells the core to copy the running time into its read buffer, so a multi-byte read of the time registers is coherent.

Top module: `rtc_spi_regif`

## Requirements
- R1: After reset, spi_miso_oe, reg_wr_en and time_snap are all low, and no register write reaches the core until a complete data byte has been received.
- R2: The level of spi_sclk when spi_cs_n falls is taken as the idle level; the block samples spi_mosi on each edge that returns the clock to idle and changes spi_miso on each edge that leaves idle. Both idle levels work.
- R3: Bytes are shifted most significant bit first. In the first byte of a transfer, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6:0 give the starting register address.
- R4: spi_miso_oe is low during the command byte, for the whole of a write transfer and while spi_cs_n is high; it is high for every bit of a read data byte whose register is not reserved.
- R5: In a read burst the pointer advances by one after each data byte and goes from 13h back to 00h; that wrap raises time_snap for one cycle.
- R6: In a write burst the pointer advances by one after each data byte and goes from 13h back to 00h (command codes 93h then 80h).
- R7: Addresses 14h to 17h and 1Ah to 7Fh are reserved: a data byte written there produces no write, a read there keeps spi_miso_oe low, and the pointer does not move.
- R8: Each falling edge of spi_cs_n raises time_snap for one cycle, so the first read of 00h to 06h returns the time as it stood when the transfer began.
- R9: Register 18h holds the memory address; register 19h reads or writes the memory byte at that address. Each data byte at 19h moves the memory address up by one (FFh rolls over to 00h) while the pointer stays at 19h; after a byte at 18h the pointer moves to 19h.
- R10: Bits that are fixed at zero read as 0 and are cleared before a write reaches the core. Kept-bit masks by address: 00h, 01h, 02h = 7Fh; 03h = 07h; 04h = 3Fh; 05h = 9Fh; 0Fh = 8Fh; 12h = C0h; 13h = 01h; every other register = FFh.
- R11: A write data byte is passed to the core (one-cycle reg_wr_en) only after its eighth bit is sampled; a byte cut short by spi_cs_n rising is discarded.
- R12: Read data for the next byte is fetched before that byte starts, so spi_miso_oe stays high across every bit of consecutive read data bytes in a burst of any length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, valid while spi_miso_oe is high |
| spi_miso_oe | output | 1 | Output enable for the data-out pad; low means high impedance |
| reg_wr_en | output | 1 | One-cycle write strobe toward the core |
| reg_wr_addr | output | 7 | Core register written by reg_wr_en |
| reg_wr_data | output | 8 | Write data with fixed-zero bits cleared |
| reg_rd_addr | output | 7 | Core register currently pointed at |
| reg_rd_data | input | 8 | Core data for reg_rd_addr, valid in the same cycle |
| time_snap | output | 1 | One-cycle strobe: copy the running time into the read buffer |

## Verification
The assertions assume the serial pins move slowly against clk: each spi_sclk half period spans at least six system cycles, spi_cs_n never changes in the same cycle as a clock edge, and the core answers reg_rd_addr combinationally and applies time_snap at the next clk edge. The bench keeps within this by running the serial clock with eight system cycles per half period, changing every input on the falling edge of clk and leaving several idle cycles around each chip-select edge; its core model updates its read buffer on the edge after the strobe. Under those conditions the properties on pointer movement, reserved addresses, write masking and output enable hold at every cycle.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;

    localparam int unsigned REG_AW = 7;
    localparam int unsigned BYTE_W = 8;

    localparam logic [REG_AW-1:0] LAST_REG     = 7'h13;
    localparam logic [REG_AW-1:0] MEM_ADDR_REG = 7'h18;
    localparam logic [REG_AW-1:0] MEM_DATA_REG = 7'h19;

    // Addresses that get no response: the gap after the last core register
    // and everything above the memory data register.
    function automatic logic is_reserved(input logic [REG_AW-1:0] a);
        return (a > LAST_REG) && (a != MEM_ADDR_REG) && (a != MEM_DATA_REG);
    endfunction

    // Bits that exist in each register; all others are fixed at zero.
    function automatic logic [BYTE_W-1:0] keep_mask(input logic [REG_AW-1:0] a);
        logic [BYTE_W-1:0] m;
        case (a)
            7'h00, 7'h01, 7'h02: m = 8'h7F;
            7'h03:               m = 8'h07;
            7'h04:               m = 8'h3F;
            7'h05:               m = 8'h9F;
            7'h0F:               m = 8'h8F;
            7'h12:               m = 8'hC0;
            7'h13:               m = 8'h01;
            default:             m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned NBITS  = 3,
    parameter logic [NBITS-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] din,
    output logic [NBITS-1:0] dout
);

    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign dout[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] pre_data,
    input  logic              pre_valid,
    output logic              cs_fall,
    output logic              byte_done,
    output logic              byte_first,
    output logic [BYTE_W-1:0] byte_val,
    output logic              miso,
    output logic              miso_oe
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic              cs_prev;
        logic              cpol;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              oe;
        logic              first;
        logic              done;
        logic              dfirst;
        logic [BYTE_W-1:0] dbyte;
    } shf_t;

    shf_t q, d;
    logic fall, lead, trail;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.sclk_prev = sclk_s;
        d.cs_prev   = cs_n_s;

        fall  = q.cs_prev && !cs_n_s;
        lead  = (q.sclk_prev == q.cpol) && (sclk_s != q.cpol);
        trail = (q.sclk_prev != q.cpol) && (sclk_s == q.cpol);

        if (cs_n_s) begin
            d.bitcnt = '0;
            d.oe     = 1'b0;
            d.first  = 1'b1;
        end else if (fall) begin
            d.cpol   = sclk_s;
            d.bitcnt = '0;
            d.oe     = 1'b0;
            d.first  = 1'b1;
        end else if (trail) begin
            d.rx     = {q.rx[BYTE_W-2:0], mosi_s};
            d.bitcnt = q.bitcnt + CNT_W'(1);
            if (q.bitcnt == LAST_BIT) begin
                d.done   = 1'b1;
                d.dbyte  = {q.rx[BYTE_W-2:0], mosi_s};
                d.dfirst = q.first;
                d.first  = 1'b0;
                d.bitcnt = '0;
            end
        end else if (lead) begin
            if (q.bitcnt == '0) begin
                d.tx = pre_data;
                d.oe = tx_en && !q.first && pre_valid;
            end else begin
                d.tx = {q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.cs_prev <= 1'b1;
            q.first   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_fall    = fall;
    assign byte_done  = q.done;
    assign byte_first = q.dfirst;
    assign byte_val   = q.dbyte;
    assign miso       = q.oe && q.tx[BYTE_W-1];
    assign miso_oe    = q.oe;

    // R4: a deselected slave releases the data-out pad on the next cycle
    a_r4_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso_oe);

    // R11: a byte needs eight clock edges, so completion is never back to back
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

endmodule

// File: rtl/rtc_spi_sram.sv
module rtc_spi_sram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          data_we,
    input  logic          data_re,
    input  logic [DW-1:0] data_wdata,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [AW-1:0] addr_d, addr_q;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        addr_d = addr_q;
        if (addr_we) begin
            addr_d = addr_wdata;
        end else if (data_we || data_re) begin
            addr_d = addr_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (data_we) begin
            mem_q[addr_q] <= data_wdata;
        end
    end

    assign addr_o  = addr_q;
    assign rdata_o = mem_q[addr_q];

    // R9: each data-register byte moves the memory address by exactly one
    a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_we || data_re) && !addr_we) |=> (addr_q == $past(addr_q) + AW'(1)));

endmodule

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif
    import rtc_spi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MEM_AW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic [REG_AW-1:0] reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rd_data,
    output logic              time_snap
);

    localparam int unsigned FCNT_W = 2;
    localparam logic [FCNT_W-1:0] FETCH_WAIT = 2'd2;

    typedef struct packed {
        logic [REG_AW-1:0] ptr;
        logic              wr_mode;
        logic              rd_mode;
        logic [FCNT_W-1:0] fcnt;
        logic [BYTE_W-1:0] pre;
        logic              pre_ok;
        logic              wr_en;
        logic [REG_AW-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic              snap;
    } ctl_t;

    ctl_t q, d;

    logic              cs_n_s, sclk_s, mosi_s;
    logic              cs_fall, byte_done, byte_first;
    logic [BYTE_W-1:0] byte_val;
    logic              rsv;
    logic [BYTE_W-1:0] rd_mux;

    logic              m_addr_we, m_data_we, m_data_re;
    logic [MEM_AW-1:0] m_addr;
    logic [BYTE_W-1:0] m_rdata;

    rtc_spi_sync #(
        .STAGES (SYNC_STAGES),
        .NBITS  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout ({cs_n_s, sclk_s, mosi_s})
    );

    rtc_spi_shifter #(
        .BYTE_W(BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .mosi_s    (mosi_s),
        .tx_en     (q.rd_mode),
        .pre_data  (q.pre),
        .pre_valid (q.pre_ok),
        .cs_fall   (cs_fall),
        .byte_done (byte_done),
        .byte_first(byte_first),
        .byte_val  (byte_val),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    rtc_spi_sram #(
        .AW(MEM_AW),
        .DW(BYTE_W)
    ) u_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_we   (m_addr_we),
        .addr_wdata(MEM_AW'(byte_val)),
        .data_we   (m_data_we),
        .data_re   (m_data_re),
        .data_wdata(byte_val),
        .addr_o    (m_addr),
        .rdata_o   (m_rdata)
    );

    // Source of the byte to be shifted out next, chosen by the pointer.
    always_comb begin
        if (q.ptr <= LAST_REG) begin
            rd_mux = reg_rd_data & keep_mask(q.ptr);
        end else if (q.ptr == MEM_ADDR_REG) begin
            rd_mux = BYTE_W'(m_addr);
        end else if (q.ptr == MEM_DATA_REG) begin
            rd_mux = m_rdata;
        end else begin
            rd_mux = '0;
        end
    end

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.snap    = 1'b0;
        m_addr_we = 1'b0;
        m_data_we = 1'b0;
        m_data_re = 1'b0;
        rsv       = is_reserved(q.ptr);

        if (q.fcnt != '0) begin
            d.fcnt = q.fcnt - FCNT_W'(1);
        end
        if (q.fcnt == FCNT_W'(1)) begin
            d.pre    = rd_mux;
            d.pre_ok = !rsv;
        end

        if (cs_n_s) begin
            d.wr_mode = 1'b0;
            d.rd_mode = 1'b0;
            d.fcnt    = '0;
        end else if (cs_fall) begin
            d.snap    = 1'b1;
            d.wr_mode = 1'b0;
            d.rd_mode = 1'b0;
            d.fcnt    = '0;
        end else if (byte_done) begin
            if (byte_first) begin
                d.ptr     = byte_val[REG_AW-1:0];
                d.wr_mode = byte_val[BYTE_W-1];
                d.rd_mode = !byte_val[BYTE_W-1];
                if (!byte_val[BYTE_W-1]) begin
                    d.fcnt = FETCH_WAIT;
                end
            end else begin
                if (!rsv) begin
                    if (q.wr_mode) begin
                        if (q.ptr <= LAST_REG) begin
                            d.wr_en   = 1'b1;
                            d.wr_addr = q.ptr;
                            d.wr_data = byte_val & keep_mask(q.ptr);
                        end else if (q.ptr == MEM_ADDR_REG) begin
                            m_addr_we = 1'b1;
                        end else begin
                            m_data_we = 1'b1;
                        end
                    end else if (q.ptr == MEM_DATA_REG) begin
                        m_data_re = 1'b1;
                    end

                    if (q.ptr == LAST_REG) begin
                        d.ptr  = '0;
                        d.snap = q.rd_mode;
                    end else if (q.ptr != MEM_DATA_REG) begin
                        d.ptr = q.ptr + REG_AW'(1);
                    end
                end
                if (q.rd_mode) begin
                    d.fcnt = FETCH_WAIT;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign reg_wr_en   = q.wr_en;
    assign reg_wr_addr = q.wr_addr;
    assign reg_wr_data = q.wr_data;
    assign reg_rd_addr = q.ptr;
    assign time_snap   = q.snap;

    // R7: the core never sees a write outside its register range
    a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wr_addr <= LAST_REG));

    // R10: fixed-zero bits are cleared on their way to the core
    a_r10_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ((reg_wr_data & ~keep_mask(reg_wr_addr)) == '0));

    // R5: a read byte at the last register wraps the pointer and takes a snapshot
    a_r5_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !byte_first && !cs_n_s && q.rd_mode && q.ptr == LAST_REG)
        |=> (q.ptr == '0 && time_snap));

    // R9: the memory data register keeps the pointer in place
    a_r9_data_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !byte_first && !cs_n_s && q.ptr == MEM_DATA_REG)
        |=> (q.ptr == MEM_DATA_REG));

    // R7: a data byte at a reserved address leaves the pointer unchanged
    a_r7_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !byte_first && !cs_n_s && is_reserved(q.ptr))
        |=> $stable(q.ptr));

endmodule

// File: tb/rtc_spi_regif_tb.sv
module rtc_spi_regif_tb;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso, spi_miso_oe;
    logic       reg_wr_en;
    logic [6:0] reg_wr_addr, reg_rd_addr;
    logic [7:0] reg_wr_data, reg_rd_data;
    logic       time_snap;

    always #2 clk = ~clk;

    rtc_spi_regif u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_cs_n   (spi_cs_n),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .spi_miso_oe(spi_miso_oe),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data),
        .time_snap  (time_snap)
    );

    // Core model: live time 00h-06h, read buffer, other registers.
    logic [7:0] live [32];
    logic [7:0] ubuf [32];
    logic [7:0] regs [32];
    int wr_count;
    int snap_cnt;

    assign reg_rd_data = (reg_rd_addr < 7'd7) ? ubuf[reg_rd_addr[4:0]] :
                         (reg_rd_addr < 7'd20) ? regs[reg_rd_addr[4:0]] : 8'hFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                live[i] <= 8'hFF;
                ubuf[i] <= 8'hFF;
                regs[i] <= 8'hFF;
            end
            wr_count <= 0;
            snap_cnt <= 0;
        end else begin
            if (time_snap) begin
                for (int i = 0; i < 7; i++) ubuf[i] <= live[i];
                snap_cnt <= snap_cnt + 1;
            end
            if (reg_wr_en) begin
                if (reg_wr_addr < 7'd7) live[reg_wr_addr[4:0]] <= reg_wr_data;
                else regs[reg_wr_addr[4:0]] <= reg_wr_data;
                wr_count <= wr_count + 1;
            end
        end
    end

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fz(input int a);
        case (a)
            0, 1, 2: return 8'h7F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h9F;
            15:      return 8'h8F;
            18:      return 8'hC0;
            19:      return 8'h01;
            default: return 8'hFF;
        endcase
    endfunction

    logic [7:0] txb [300];
    logic [7:0] rxb [300];
    logic       oeall [300];
    logic       oeany [300];

    task automatic xfer(input logic pol, input int nbytes, input int cut);
        spi_sclk = pol;
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] r;
            logic alo, ano;
            r = 8'h00; alo = 1'b1; ano = 1'b0;
            for (int i = 7; i >= 0; i--) begin
                spi_sclk = ~pol;
                spi_mosi = txb[b][i];
                repeat (H) @(negedge clk);
                r[i] = spi_miso;
                alo = alo & spi_miso_oe;
                ano = ano | spi_miso_oe;
                spi_sclk = pol;
                repeat (H) @(negedge clk);
            end
            rxb[b] = r; oeall[b] = alo; oeany[b] = ano;
        end
        for (int i = 7; i > 7 - cut; i--) begin
            spi_sclk = ~pol;
            spi_mosi = txb[nbytes][i];
            repeat (H) @(negedge clk);
            spi_sclk = pol;
            repeat (H) @(negedge clk);
        end
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w0, s0;
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1 oe", int'(spi_miso_oe), 0);
        chk("R1 wr_en", int'(reg_wr_en), 0);
        chk("R1 snap", int'(time_snap), 0);

        // R10 read masking of raw core value, R4 enables, mode with idle-low clock
        txb[0] = 8'h0F; txb[1] = 8'h00;
        xfer(1'b0, 2, 0);
        chk("R10 read mask 0Fh", int'(rxb[1]), 8'h8F);
        chk("R4 oe off in command", int'(oeany[0]), 0);
        chk("R4 oe on in read data", int'(oeall[1]), 1);
        chk("R4 oe off after deselect", int'(spi_miso_oe), 0);

        // R2/R3: write with idle-high clock, read back in both modes
        txb[0] = 8'h90; txb[1] = 8'h5A;
        xfer(1'b1, 2, 0);
        chk("R3 write reaches core", int'(regs[16]), 8'h5A);
        chk("R4 oe off in write", int'(oeany[1]), 0);
        txb[0] = 8'h10; txb[1] = 8'h00;
        xfer(1'b0, 2, 0);
        chk("R2 read idle-low", int'(rxb[1]), 8'h5A);
        xfer(1'b1, 2, 0);
        chk("R2 read idle-high", int'(rxb[1]), 8'h5A);

        // R11: byte cut short is discarded
        w0 = wr_count;
        txb[0] = 8'h90; txb[1] = 8'hFF;
        xfer(1'b1, 1, 5);
        chk("R11 partial byte no write", wr_count - w0, 0);
        txb[0] = 8'h10;
        xfer(1'b0, 2, 0);
        chk("R11 register kept", int'(rxb[1]), 8'h5A);

        // R10: all-ones write burst over the whole core range, then read back
        w0 = wr_count;
        txb[0] = 8'h80;
        for (int i = 1; i <= 20; i++) txb[i] = 8'hFF;
        xfer(1'b0, 21, 0);
        chk("R11 one write per byte", wr_count - w0, 20);
        txb[0] = 8'h00;
        xfer(1'b1, 21, 0);
        for (int i = 0; i < 20; i++) begin
            chk($sformatf("R10 mask reg %0h", i), int'(rxb[1 + i]), int'(fz(i)));
        end

        // R6: write burst wrap 13h -> 00h
        w0 = wr_count;
        txb[0] = 8'h92; txb[1] = 8'h40; txb[2] = 8'h01; txb[3] = 8'h25;
        xfer(1'b1, 4, 0);
        chk("R6 writes", wr_count - w0, 3);
        chk("R6 reg 12h", int'(regs[18]), 8'h40);
        chk("R6 reg 13h", int'(regs[19]), 8'h01);
        chk("R6 wrapped to 00h", int'(live[0]), 8'h25);

        // R8 snapshot on select, R5 read wrap with snapshot, R12 no gap
        s0 = snap_cnt;
        txb[0] = 8'h12;
        xfer(1'b0, 4, 0);
        chk("R5 read 12h", int'(rxb[1]), 8'h40);
        chk("R5 read 13h", int'(rxb[2]), 8'h01);
        chk("R8 read 00h after wrap", int'(rxb[3]), 8'h25);
        chk("R5 R8 snapshot count", snap_cnt - s0, 2);

        // R7: reserved addresses
        w0 = wr_count;
        txb[0] = 8'h94; txb[1] = 8'hAA; txb[2] = 8'hBB;
        xfer(1'b0, 3, 0);
        chk("R7 no write reserved", wr_count - w0, 0);
        txb[0] = 8'h15; txb[1] = 8'h00; txb[2] = 8'h00;
        xfer(1'b1, 3, 0);
        chk("R7 read 15h silent", int'(oeany[1] | oeany[2]), 0);
        txb[0] = 8'h7F;
        xfer(1'b0, 2, 0);
        chk("R7 read 7Fh silent", int'(oeany[1]), 0);
        txb[0] = 8'h98; txb[1] = 8'h33;
        xfer(1'b0, 2, 0);
        txb[0] = 8'h97; txb[1] = 8'h05; txb[2] = 8'h06; txb[3] = 8'h07;
        xfer(1'b1, 4, 0);
        txb[0] = 8'h18;
        xfer(1'b0, 2, 0);
        chk("R7 pointer held at 17h", int'(rxb[1]), 8'h33);

        // R9: fill all memory through one burst, read all back
        txb[0] = 8'h98; txb[1] = 8'h00;
        for (int i = 0; i < 256; i++) txb[2 + i] = pat(i);
        xfer(1'b0, 258, 0);
        txb[0] = 8'h98; txb[1] = 8'h00;
        xfer(1'b1, 2, 0);
        txb[0] = 8'h19;
        for (int i = 1; i <= 256; i++) txb[i] = 8'h00;
        xfer(1'b0, 257, 0);
        begin
            int gaps = 0;
            for (int i = 0; i < 256; i++) begin
                chk($sformatf("R9 mem %0h", i), int'(rxb[1 + i]), int'(pat(i)));
                if (!oeall[1 + i]) gaps++;
            end
            chk("R12 no gap in long burst", gaps, 0);
        end
        txb[0] = 8'h18;
        xfer(1'b1, 2, 0);
        chk("R9 address after 256 steps", int'(rxb[1]), 8'h00);

        // R9: rollover FFh -> 00h
        txb[0] = 8'h98; txb[1] = 8'hFF; txb[2] = 8'hC3; txb[3] = 8'h3C;
        xfer(1'b0, 4, 0);
        txb[0] = 8'h18;
        xfer(1'b0, 2, 0);
        chk("R9 address rolled", int'(rxb[1]), 8'h01);
        txb[0] = 8'h98; txb[1] = 8'hFF;
        xfer(1'b1, 2, 0);
        txb[0] = 8'h19;
        xfer(1'b1, 3, 0);
        chk("R9 mem FFh", int'(rxb[1]), 8'hC3);
        chk("R9 mem 00h", int'(rxb[2]), 8'h3C);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule